// File: doc/BRIEF.md
# Store-Pair-Direct Bus Sequencer

This block runs one fixed instruction on a byte-wide memory bus: it stores a 16-bit register pair at a memory address given inside the instruction. After a start request it fetches the opcode at the program counter. It then reads the two address bytes that follow the opcode. Last, it performs two writes: the low register goes to the direct address and the high register goes to the next address. Each machine cycle is split into T-states of one clock each. The current machine cycle and T-state are visible on a status output, so a bus model or a debug probe can follow the sequence clock by clock.

The register pair is loaded through a side port while the sequencer is idle. The program counter starts at a parameterised reset value. A legal instruction moves it forward by three bytes. A fetched byte that is not the store opcode makes the sequencer skip the stores, raise an illegal-opcode pulse and move the counter past that one byte.

Top module: `pair_store_seq`

## Requirements
- R1: During and right after reset the sequencer is idle. The machine-cycle status is 0, the T-state status is 0, both strobes are low, done and illegal are low, and the address bus reads 0.
- R2: After a start request seen while idle, an opcode-fetch cycle (status code 1) of FETCH_T T-states begins on the next clock. Its address is the program counter, and the read strobe is high in T-states 2 to FETCH_T-1 only.
- R3: The two following memory-read cycles (codes 2 and 3) each last MEM_T T-states and use addresses PC+1 and PC+2. Their read strobes are high in T-states 2 to MEM_T-1. The first byte read is the low byte of the direct address and the second is the high byte.
- R4: Two memory-write cycles follow (codes 4 and 5), MEM_T T-states each. The first writes the L register to the direct address, and the second writes the H register to the direct address plus one. The write strobe is high in T-states 2 to MEM_T-1 only.
- R5: The direct address plus one wraps modulo 2^16, so a direct address of 0xFFFF puts H at 0x0000.
- R6: The status runs through codes 1,2,3,4,5 and then back to 0. T-states count from 1 within each cycle. With the default timing a store takes 16 clocks.
- R7: The read and write strobes are never high in the same clock. The address bus holds one value for the whole of each machine cycle.
- R8: done is high for exactly one clock: the clock after the last T-state of the second write. At the same point the program counter advances by 3.
- R9: If the fetched byte is not 0x22, no write cycle occurs and illegal pulses for one clock right after the fetch. The program counter advances by 1 and the sequencer returns to idle.
- R10: start is ignored while a sequence is running. No extra fetch begins and the running sequence keeps its length.
- R11: A register-pair load (H in the upper byte of the load data, L in the lower byte) takes effect only while idle. A load attempted mid-sequence does not change the stored values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one T-state per period |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence when idle |
| hl_load | input | 1 | Load the register pair (idle only) |
| hl_data | input | 2*DATA_W | Pair value, H in upper half, L in lower half |
| rdata | input | DATA_W | Read data from memory |
| addr | output | 2*DATA_W | Memory address bus |
| wdata | output | DATA_W | Write data bus |
| rd_en | output | 1 | Read strobe, active high |
| wr_en | output | 1 | Write strobe, active high |
| done | output | 1 | One-clock completion pulse |
| illegal | output | 1 | One-clock illegal-opcode pulse |
| mcycle | output | 3 | Machine-cycle code (0 idle, 1 fetch, 2/3 reads, 4/5 writes) |
| tstate | output | TW | Current T-state, 0 when idle |

## Verification
The bench instantiates the block with PC_RESET set to 0x0040 and every other parameter at its default. Programs can therefore sit at a known low-byte window of a 256-byte sparse memory, which leaves the direct-address targets, including 0xFFFF and its wrap to 0x0000, in non-overlapping byte slots. The default timing, FETCH_T=4 and MEM_T=3, gives the fetch a two-T-state read window and each memory cycle a one-T-state window. The bench therefore checks strobe placement that differs between cycle kinds. It also runs back-to-back instructions from the reset program counter, so the +3 and +1 counter advances show up as fetch addresses.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [2:0] {
    MC_IDLE  = 3'd0,
    MC_FETCH = 3'd1,
    MC_RDLO  = 3'd2,
    MC_RDHI  = 3'd3,
    MC_WRLO  = 3'd4,
    MC_WRHI  = 3'd5
  } mcyc_e;
endpackage

// File: rtl/sps_cycle_ctl.sv
module sps_cycle_ctl
  import sps_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3,
  parameter int TW      = 3,
  parameter logic [DATA_W-1:0] OPCODE = 8'h22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] rdata,
  output mcyc_e             mc_q,
  output logic [TW-1:0]     t_q,
  output mcyc_e             mc_n,
  output logic [TW-1:0]     t_n,
  output logic              fin_ok,
  output logic              fin_bad,
  output logic              done_o,
  output logic              illegal_o
);
  localparam logic [TW-1:0] FETCH_LEN = TW'(FETCH_T);
  localparam logic [TW-1:0] MEM_LEN   = TW'(MEM_T);
  localparam logic [TW-1:0] OP_CAP_T  = TW'(FETCH_T - 1);

  logic [DATA_W-1:0] opcode_q;
  logic [TW-1:0]     len_q;
  logic              last_t;
  logic              op_ok;

  assign len_q   = (mc_q == MC_FETCH) ? FETCH_LEN : MEM_LEN;
  assign last_t  = (mc_q != MC_IDLE) && (t_q == len_q);
  assign op_ok   = (opcode_q == OPCODE);
  assign fin_ok  = (mc_q == MC_WRHI) && last_t;
  assign fin_bad = (mc_q == MC_FETCH) && last_t && !op_ok;

  always_comb begin
    mc_n = mc_q;
    t_n  = t_q;
    if (mc_q == MC_IDLE) begin
      if (start) begin
        mc_n = MC_FETCH;
        t_n  = TW'(1);
      end else begin
        t_n  = '0;
      end
    end else if (!last_t) begin
      t_n = t_q + TW'(1);
    end else begin
      t_n = TW'(1);
      case (mc_q)
        MC_FETCH: begin
          if (op_ok) begin
            mc_n = MC_RDLO;
          end else begin
            mc_n = MC_IDLE;
            t_n  = '0;
          end
        end
        MC_RDLO: mc_n = MC_RDHI;
        MC_RDHI: mc_n = MC_WRLO;
        MC_WRLO: mc_n = MC_WRHI;
        default: begin
          mc_n = MC_IDLE;
          t_n  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q      <= MC_IDLE;
      t_q       <= '0;
      opcode_q  <= '0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      mc_q      <= mc_n;
      t_q       <= t_n;
      done_o    <= fin_ok;
      illegal_o <= fin_bad;
      if (mc_q == MC_FETCH && t_q == OP_CAP_T)
        opcode_q <= rdata;
    end
  end

  assert_fetch_from_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (mc_q == MC_FETCH && t_q == TW'(1)) |-> $past(mc_q == MC_IDLE));

  assert_read_follows_fetch_R6: assert property (@(posedge clk) disable iff (rst)
    (mc_q == MC_RDLO && t_q == TW'(1)) |-> $past(mc_q == MC_FETCH && t_q == FETCH_LEN));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(mc_q == MC_WRHI && t_q == MEM_LEN));

  assert_illegal_after_fetch_R9: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($past(mc_q == MC_FETCH && t_q == FETCH_LEN) && mc_q == MC_IDLE));
endmodule

// File: rtl/sps_operand_regs.sv
module sps_operand_regs
  import sps_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MEM_T    = 3,
  parameter int TW       = 3,
  parameter logic [2*DATA_W-1:0] PC_RESET = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  mcyc_e               mc_q,
  input  logic [TW-1:0]       t_q,
  input  logic [DATA_W-1:0]   rdata,
  input  logic                hl_load,
  input  logic [2*DATA_W-1:0] hl_data,
  input  logic                fin_ok,
  input  logic                fin_bad,
  output logic [2*DATA_W-1:0] pc_q,
  output logic [2*DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0]   h_q,
  output logic [DATA_W-1:0]   l_q
);
  localparam int AW = 2 * DATA_W;
  localparam logic [TW-1:0] CAP_T = TW'(MEM_T - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= PC_RESET;
      dir_q <= '0;
      h_q   <= '0;
      l_q   <= '0;
    end else begin
      if (fin_ok)
        pc_q <= pc_q + AW'(3);
      else if (fin_bad)
        pc_q <= pc_q + AW'(1);
      if (mc_q == MC_RDLO && t_q == CAP_T)
        dir_q[DATA_W-1:0] <= rdata;
      if (mc_q == MC_RDHI && t_q == CAP_T)
        dir_q[AW-1:DATA_W] <= rdata;
      if (mc_q == MC_IDLE && hl_load) begin
        h_q <= hl_data[AW-1:DATA_W];
        l_q <= hl_data[DATA_W-1:0];
      end
    end
  end

  assert_pair_frozen_busy_R11: assert property (@(posedge clk) disable iff (rst)
    (mc_q != MC_IDLE) |=> $stable({h_q, l_q}));
endmodule

// File: rtl/sps_bus_drive.sv
module sps_bus_drive
  import sps_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3,
  parameter int TW      = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  mcyc_e               mc_n,
  input  logic [TW-1:0]       t_n,
  input  mcyc_e               mc_q,
  input  logic [TW-1:0]       t_q,
  input  logic [2*DATA_W-1:0] pc_q,
  input  logic [2*DATA_W-1:0] dir_q,
  input  logic [DATA_W-1:0]   h_q,
  input  logic [DATA_W-1:0]   l_q,
  output logic [2*DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0]   wdata_o,
  output logic                rd_o,
  output logic                wr_o
);
  localparam int AW = 2 * DATA_W;

  logic [AW-1:0]     addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic [TW-1:0]     len_n;
  logic              mid_n;
  logic              is_rd_n;
  logic              is_wr_n;

  always_comb begin
    len_n   = (mc_n == MC_FETCH) ? TW'(FETCH_T) : TW'(MEM_T);
    mid_n   = (t_n >= TW'(2)) && (t_n <= len_n - TW'(1));
    is_rd_n = (mc_n == MC_FETCH) || (mc_n == MC_RDLO) || (mc_n == MC_RDHI);
    is_wr_n = (mc_n == MC_WRLO) || (mc_n == MC_WRHI);
    wdata_d = '0;
    case (mc_n)
      MC_FETCH: addr_d = pc_q;
      MC_RDLO:  addr_d = pc_q + AW'(1);
      MC_RDHI:  addr_d = pc_q + AW'(2);
      MC_WRLO: begin
        addr_d  = dir_q;
        wdata_d = l_q;
      end
      MC_WRHI: begin
        addr_d  = dir_q + AW'(1);
        wdata_d = h_q;
      end
      default:  addr_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      wdata_o <= '0;
      rd_o    <= 1'b0;
      wr_o    <= 1'b0;
    end else begin
      addr_o  <= addr_d;
      wdata_o <= wdata_d;
      rd_o    <= is_rd_n && mid_n;
      wr_o    <= is_wr_n && mid_n;
    end
  end

  assert_strobes_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(rd_o && wr_o));

  assert_addr_held_R7: assert property (@(posedge clk) disable iff (rst)
    (mc_q != MC_IDLE && t_q != TW'(1)) |-> $stable(addr_o));

  assert_no_strobe_edges_R4: assert property (@(posedge clk) disable iff (rst)
    (t_q == TW'(1) || mc_q == MC_IDLE) |-> (!rd_o && !wr_o));
endmodule

// File: rtl/pair_store_seq.sv
module pair_store_seq
  import sps_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FETCH_T = 4,
  parameter int MEM_T   = 3,
  parameter logic [DATA_W-1:0] OPCODE = 8'h22,
  parameter logic [2*DATA_W-1:0] PC_RESET = '0,
  localparam int AW = 2 * DATA_W,
  localparam int TW = $clog2(FETCH_T + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hl_load,
  input  logic [AW-1:0]     hl_data,
  input  logic [DATA_W-1:0] rdata,
  output logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] wdata,
  output logic              rd_en,
  output logic              wr_en,
  output logic              done,
  output logic              illegal,
  output logic [2:0]        mcycle,
  output logic [TW-1:0]     tstate
);
  mcyc_e             mc_q, mc_n;
  logic [TW-1:0]     t_q, t_n;
  logic              fin_ok, fin_bad;
  logic [AW-1:0]     pc_q, dir_q;
  logic [DATA_W-1:0] h_q, l_q;

  sps_cycle_ctl #(
    .DATA_W(DATA_W), .FETCH_T(FETCH_T), .MEM_T(MEM_T), .TW(TW), .OPCODE(OPCODE)
  ) u_ctl (
    .clk(clk), .rst(rst), .start(start), .rdata(rdata),
    .mc_q(mc_q), .t_q(t_q), .mc_n(mc_n), .t_n(t_n),
    .fin_ok(fin_ok), .fin_bad(fin_bad),
    .done_o(done), .illegal_o(illegal)
  );

  sps_operand_regs #(
    .DATA_W(DATA_W), .MEM_T(MEM_T), .TW(TW), .PC_RESET(PC_RESET)
  ) u_regs (
    .clk(clk), .rst(rst), .mc_q(mc_q), .t_q(t_q), .rdata(rdata),
    .hl_load(hl_load), .hl_data(hl_data),
    .fin_ok(fin_ok), .fin_bad(fin_bad),
    .pc_q(pc_q), .dir_q(dir_q), .h_q(h_q), .l_q(l_q)
  );

  sps_bus_drive #(
    .DATA_W(DATA_W), .FETCH_T(FETCH_T), .MEM_T(MEM_T), .TW(TW)
  ) u_bus (
    .clk(clk), .rst(rst), .mc_n(mc_n), .t_n(t_n), .mc_q(mc_q), .t_q(t_q),
    .pc_q(pc_q), .dir_q(dir_q), .h_q(h_q), .l_q(l_q),
    .addr_o(addr), .wdata_o(wdata), .rd_o(rd_en), .wr_o(wr_en)
  );

  assign mcycle = mc_q;
  assign tstate = t_q;

  assert_done_illegal_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));
endmodule

// File: tb/test_pair_store_seq.sv
module test_pair_store_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        hl_load = 1'b0;
  logic [15:0] hl_data = '0;
  logic [7:0]  rdata;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_en, wr_en, done, illegal;
  logic [2:0]  mcycle;
  logic [2:0]  tstate;

  logic [7:0] mem [0:255];
  assign rdata = mem[addr[7:0]];

  pair_store_seq #(.PC_RESET(16'h0040)) i_pair_store_seq (
    .clk(clk), .rst(rst), .start(start), .hl_load(hl_load), .hl_data(hl_data),
    .rdata(rdata), .addr(addr), .wdata(wdata), .rd_en(rd_en), .wr_en(wr_en),
    .done(done), .illegal(illegal), .mcycle(mcycle), .tstate(tstate)
  );

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, busy_cnt = 0, done_cnt = 0, ill_cnt = 0, done_t = 0;
  int strobe_bad = 0, stab_bad = 0, wn = 0;
  int tcnt [0:7];
  int mc_addr [0:7];
  int wlog_a [0:15];
  int wlog_d [0:15];
  int wlog_t [0:15];
  logic [15:0] prev_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bus monitor: memory writes and timing bookkeeping, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      bit er, ew;
      er = (mcycle == 3'd1 && (tstate == 3'd2 || tstate == 3'd3)) ||
           ((mcycle == 3'd2 || mcycle == 3'd3) && tstate == 3'd2);
      ew = (mcycle == 3'd4 || mcycle == 3'd5) && tstate == 3'd2;
      if (rd_en !== er || wr_en !== ew || (rd_en && wr_en)) strobe_bad++;
      if (mcycle != 3'd0) busy_cnt++;
      tcnt[mcycle]++;
      if (tstate == 3'd1) mc_addr[mcycle] = int'(addr);
      else if (mcycle != 3'd0 && addr != prev_addr) stab_bad++;
      if (wr_en) begin
        mem[addr[7:0]] = wdata;
        if (wn < 16) begin
          wlog_a[wn] = int'(addr);
          wlog_d[wn] = int'(wdata);
          wlog_t[wn] = cyc;
        end
        wn++;
      end
      if (done) begin
        done_cnt++;
        done_t = cyc;
      end
      if (illegal) ill_cnt++;
      prev_addr = addr;
      cyc++;
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", wd, 20000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic check_reset();
    check(mcycle == 3'd0 && tstate == 3'd0, "R1", "idle status", int'({mcycle, tstate}), 0);
    check(!rd_en && !wr_en && !done && !illegal, "R1", "control outputs low",
          int'({rd_en, wr_en, done, illegal}), 0);
    check(addr == 16'h0000, "R1", "address bus", int'(addr), 0);
  endtask

  // one instruction; disturb drives start and a pair load mid-sequence
  task automatic run_store(input int pc, input int d, input int hv, input int lv,
                           input int opc, input bit disturb);
    int s_busy, s_wn, s_done, s_ill, s_strobe, s_stab, k;
    int s_t [0:7];
    bit legal;
    legal = (opc == 'h22);
    mem[pc & 255]       = 8'(opc);
    mem[(pc + 1) & 255] = 8'(d & 255);
    mem[(pc + 2) & 255] = 8'(d >> 8);
    mem[d & 255]        = 8'hCC;
    mem[(d + 1) & 255]  = 8'hDD;
    @(negedge clk);
    hl_load = 1'b1;
    hl_data = 16'((hv << 8) | lv);
    @(negedge clk);
    hl_load = 1'b0;
    s_busy = busy_cnt; s_wn = wn; s_done = done_cnt; s_ill = ill_cnt;
    s_strobe = strobe_bad; s_stab = stab_bad;
    for (int i = 0; i < 8; i++) s_t[i] = tcnt[i];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      hl_load = 1'b1;
      hl_data = 16'h5566;
      repeat (5) @(negedge clk);
      start = 1'b0;
      hl_load = 1'b0;
    end
    k = 0;
    while (done_cnt == s_done && ill_cnt == s_ill && k < 100) begin
      @(negedge clk);
      k++;
    end
    repeat (4) @(negedge clk);

    check(mc_addr[1] == pc, "R2", "fetch address = PC", mc_addr[1], pc);
    check(tcnt[1] - s_t[1] == 4, "R2", "fetch T-states", tcnt[1] - s_t[1], 4);
    check(strobe_bad == s_strobe, "R7", "strobe placement/exclusion", strobe_bad - s_strobe, 0);
    check(stab_bad == s_stab, "R7", "address held per cycle", stab_bad - s_stab, 0);
    if (legal) begin
      check(busy_cnt - s_busy == 16, "R6", "total busy clocks", busy_cnt - s_busy, 16);
      for (int m = 2; m <= 5; m++)
        check(tcnt[m] - s_t[m] == 3, "R6", "T-states per memory cycle", tcnt[m] - s_t[m], 3);
      check(mc_addr[2] == ((pc + 1) & 'hFFFF), "R3", "low operand address", mc_addr[2], (pc + 1) & 'hFFFF);
      check(mc_addr[3] == ((pc + 2) & 'hFFFF), "R3", "high operand address", mc_addr[3], (pc + 2) & 'hFFFF);
      check(wn - s_wn == 2, "R4", "write count", wn - s_wn, 2);
      check(wlog_a[s_wn] == d && wlog_d[s_wn] == lv, "R4", "L write addr/data",
            (wlog_a[s_wn] << 8) | wlog_d[s_wn], (d << 8) | lv);
      check(wlog_a[s_wn + 1] == ((d + 1) & 'hFFFF), "R5", "H write address",
            wlog_a[s_wn + 1], (d + 1) & 'hFFFF);
      check(wlog_d[s_wn + 1] == hv, "R4", "H write data", wlog_d[s_wn + 1], hv);
      check(mem[d & 255] == 8'(lv) && mem[(d + 1) & 255] == 8'(hv), "R4", "memory contents",
            int'({mem[d & 255], mem[(d + 1) & 255]}), (lv << 8) | hv);
      check(done_cnt - s_done == 1, "R8", "done pulse count", done_cnt - s_done, 1);
      check(done_t == wlog_t[s_wn + 1] + 2, "R8", "done timing", done_t, wlog_t[s_wn + 1] + 2);
      check(ill_cnt == s_ill, "R9", "no illegal on legal opcode", ill_cnt - s_ill, 0);
      if (disturb) begin
        check(busy_cnt - s_busy == 16 && mcycle == 3'd0, "R10", "start while busy ignored",
              busy_cnt - s_busy, 16);
        check(wlog_d[s_wn] == lv && wlog_d[s_wn + 1] == hv, "R11", "load while busy ignored",
              (wlog_d[s_wn + 1] << 8) | wlog_d[s_wn], (hv << 8) | lv);
      end
    end else begin
      check(busy_cnt - s_busy == 4, "R9", "illegal busy clocks", busy_cnt - s_busy, 4);
      check(wn == s_wn, "R9", "no writes on illegal", wn - s_wn, 0);
      check(ill_cnt - s_ill == 1, "R9", "illegal pulse count", ill_cnt - s_ill, 1);
      check(done_cnt == s_done, "R9", "no done on illegal", done_cnt - s_done, 0);
      check(mem[d & 255] == 8'hCC && mem[(d + 1) & 255] == 8'hDD, "R9", "memory untouched",
            int'({mem[d & 255], mem[(d + 1) & 255]}), 'hCCDD);
    end
  endtask

  task automatic check_next_pc(input int pc);
    int s_busy;
    s_busy = busy_cnt;
    check(mcycle == 3'd0, "R8", "idle before next start", int'(mcycle), 0);
    check(busy_cnt == s_busy, "R8", "no spurious activity", busy_cnt - s_busy, 0);
    mem[pc & 255] = 8'h22;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) begin
      tcnt[i] = 0;
      mc_addr[i] = 0;
    end
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    @(negedge clk);
    check_reset();
    run_store('h0040, 'h4050, 'hBB, 'hAA, 'h22, 1'b0);
    check_next_pc('h0043);
    run_store('h0043, 'hFFFF, 'h12, 'h34, 'h22, 1'b0);
    run_store('h0046, 'h2090, 'h00, 'h00, 'h76, 1'b0);
    run_store('h0047, 'h1280, 'h9A, 'h5C, 'h22, 1'b1);
    run_store('h004A, 'h30A0, 'hF0, 'h0F, 'h22, 1'b0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule